// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits on the host side of a parallel NAND flash device and turns simple operation requests into bus cycles on the 8-bit flash interface. A request names one of four operations: send a command byte, send a full address, write a burst of data bytes, or read a burst of data bytes. The sequencer drives chip enable, the two latch enables, write enable and read enable in the level combination each operation needs. It produces every byte strobe with low and high phase lengths taken from configuration inputs counted in clock cycles.

Bytes to be written arrive on a valid/ready input stream. Bytes read from the device leave on a valid/ready output stream through a one-entry holding register. When that register is full, the next read strobe waits until the consumer takes the byte. The I/O bus is given as separate output, output-enable and input signals, so the pad ring builds the tristate buffer. Configuration inputs must stay constant while the block is busy.

Top module: `nand_bus_seq`

## Requirements
- R1: Idle state. After reset and between operations, the outputs are `nand_ce_n`=1, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_io_oe`=0, `busy`=0 and `req_ready`=1.
- R2: Command operation (`req_op`=0). The block gives exactly one write-enable pulse. During it, chip enable is low, `nand_cle`=1, `nand_ale`=0, read enable is high and the bus is driven with `req_cmd`.
- R3: Address operation (`req_op`=1). The block gives exactly five write-enable pulses with `nand_ale`=1 and `nand_cle`=0. The bytes of `req_addr` are sent least significant byte first: bits 7:0, then 15:8, and so on up to 39:32.
- R4: Data-in operation (`req_op`=2). Both latch enables are low. There is one write-enable pulse for each byte, and `req_len` bytes are sent (a value of 0 counts as 1), taken in order from the write stream. While `wr_valid` is low, write enable stays high and the operation waits.
- R5: Data-out operation (`req_op`=3). Write enable stays high, both latch enables are low and the bus is not driven. Read enable is pulsed `req_len` times (0 counts as 1). `nand_io_in` is sampled in the last cycle of each read-enable low phase and delivered in order on `rd_data`.
- R6: Strobe widths. Each write-enable low phase lasts exactly max(`cfg_we_lo`,1) cycles. Each read-enable low phase lasts exactly max(`cfg_re_lo`,1) cycles. Between two strobes of one operation, the strobe stays high for at least max(`cfg_we_hi`,1) or max(`cfg_re_hi`,1) cycles.
- R7: Read stream back-pressure. While `rd_valid`=1 and `rd_ready`=0, `rd_valid` stays 1 and `rd_data` does not change. No new read-enable pulse begins while the holding register is full.
- R8: Busy. `busy` is 1 from the cycle after a request is accepted (`req_valid` and `req_ready` both 1). It falls exactly one full high phase after the final strobe of the operation rises. `req_ready` equals the inverse of `busy`.
- R9: Bus safety. Write enable and read enable are never low together. `nand_io_oe` is 0 whenever read enable is low, and chip enable stays low while `busy`=1. The latch enables and the bus byte stay stable while a write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_lo | input | CW | Write-enable low phase in cycles (0 treated as 1) |
| cfg_we_hi | input | CW | Write-enable high phase in cycles (0 treated as 1) |
| cfg_re_lo | input | CW | Read-enable low phase in cycles (0 treated as 1) |
| cfg_re_hi | input | CW | Read-enable high phase in cycles (0 treated as 1) |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_op | input | 2 | 0 command, 1 address, 2 data in, 3 data out |
| req_cmd | input | DW | Command byte |
| req_addr | input | AB*DW | Address bytes, least significant sent first |
| req_len | input | LW | Burst length for data operations |
| busy | output | 1 | Operation in progress |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | DW | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | DW | Read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | DW | Bus value to drive |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | DW | Bus value sampled from the pads |

## Verification
The bench sends an address with five distinct byte values. A design that sends the address bytes in reverse order, or gives four or six pulses, leaves the scoreboard with a mismatch or with leftover entries. It measures every strobe phase with the configuration set to one, to several cycles and to zero. An off-by-one timer or a missing zero clamp then shows up as a wrong low width or a short high gap. It holds the write stream empty and the read consumer stalled partway through bursts. A design that strobes without data, drops a byte or overwrites the holding register is caught by a pulse count or a changed `rd_data`. It also times the fall of `busy` against the final strobe's rise, which catches a design that ends the operation one phase early or late.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    NBS_CMD   = 2'd0,
    NBS_ADDR  = 2'd1,
    NBS_WDATA = 2'd2,
    NBS_RDATA = 2'd3
  } nbs_op_e;

  typedef enum logic [1:0] {
    NBS_IDLE = 2'd0,
    NBS_WAIT = 2'd1,
    NBS_LO   = 2'd2,
    NBS_HI   = 2'd3
  } nbs_st_e;
endpackage

// File: rtl/nbs_phase_timer.sv
module nbs_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_ln,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? ONE : load_val;
    end else if (cnt_q > ONE) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      cnt_q <= ONE;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q <= ONE);
endmodule

// File: rtl/nbs_byte_src.sv
module nbs_byte_src import nbs_pkg::*; #(
  parameter int DW = 8,
  parameter int AB = 5
) (
  input  logic            clk,
  input  logic            rst_ln,
  input  logic            accept,
  input  logic [DW-1:0]   acc_cmd,
  input  logic [AB*DW-1:0] acc_addr,
  input  nbs_op_e         op,
  input  logic            go_lo,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   io_out
);
  localparam int AW = AB * DW;

  logic [DW-1:0] cmd_q, io_q, io_d;
  logic [AW-1:0] sh_q, sh_d;

  always_comb begin
    io_d = io_q;
    sh_d = sh_q;
    if (go_lo) begin
      case (op)
        NBS_CMD:   io_d = cmd_q;
        NBS_ADDR: begin
          io_d = sh_q[DW-1:0];
          sh_d = sh_q >> DW;
        end
        NBS_WDATA: io_d = wr_data;
        default:   io_d = io_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      cmd_q <= '0;
      sh_q  <= '0;
      io_q  <= '0;
    end else begin
      if (accept) begin
        cmd_q <= acc_cmd;
        sh_q  <= acc_addr;
      end else begin
        sh_q  <= sh_d;
      end
      io_q <= io_d;
    end
  end

  assign io_out = io_q;
endmodule

// File: rtl/nbs_rd_buf.sv
module nbs_rd_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ln,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (capture) begin
        vld_q <= 1'b1;
        dat_q <= din;
      end else if (vld_q && rd_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = dat_q;

  // R7: a held byte stays valid and unchanged until taken
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_ln)
    (vld_q && !rd_ready) |=> (vld_q && $stable(dat_q)));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq import nbs_pkg::*; #(
  parameter int DW = 8,
  parameter int AB = 5,
  parameter int CW = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_we_lo,
  input  logic [CW-1:0]    cfg_we_hi,
  input  logic [CW-1:0]    cfg_re_lo,
  input  logic [CW-1:0]    cfg_re_hi,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [DW-1:0]    req_cmd,
  input  logic [AB*DW-1:0] req_addr,
  input  logic [LW-1:0]    req_len,
  output logic             busy,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [DW-1:0]    nand_io_out,
  output logic             nand_io_oe,
  input  logic [DW-1:0]    nand_io_in
);
  localparam logic [LW-1:0] LEN_ONE  = LW'(1);
  localparam logic [LW-1:0] ADDR_CNT = LW'(AB);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ln = rs_q[1];

  nbs_st_e       st_q, st_d;
  nbs_op_e       op_q, op_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          accept, go_lo, can_go, capture;
  logic          tmr_load, tmr_last;
  logic [CW-1:0] tmr_val, lo_sel, hi_sel;

  assign lo_sel = (op_q == NBS_RDATA) ? cfg_re_lo : cfg_we_lo;
  assign hi_sel = (op_q == NBS_RDATA) ? cfg_re_hi : cfg_we_hi;

  always_comb begin
    case (op_q)
      NBS_WDATA: can_go = wr_valid;
      NBS_RDATA: can_go = !rd_valid;
      default:   can_go = 1'b1;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    rem_d    = rem_q;
    go_lo    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = lo_sel;
    accept   = 1'b0;
    case (st_q)
      NBS_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          st_d   = NBS_WAIT;
          op_d   = nbs_op_e'(req_op);
          case (nbs_op_e'(req_op))
            NBS_CMD:  rem_d = LEN_ONE;
            NBS_ADDR: rem_d = ADDR_CNT;
            default:  rem_d = (req_len == '0) ? LEN_ONE : req_len;
          endcase
        end
      end
      NBS_WAIT: begin
        if (can_go) begin
          st_d  = NBS_LO;
          go_lo = 1'b1;
        end
      end
      NBS_LO: begin
        if (tmr_last) begin
          st_d     = NBS_HI;
          tmr_load = 1'b1;
          tmr_val  = hi_sel;
        end
      end
      default: begin
        if (tmr_last) begin
          rem_d = rem_q - LEN_ONE;
          if (rem_q <= LEN_ONE) begin
            st_d = NBS_IDLE;
          end else if (can_go) begin
            st_d  = NBS_LO;
            go_lo = 1'b1;
          end else begin
            st_d = NBS_WAIT;
          end
        end
      end
    endcase
    if (go_lo) begin
      tmr_load = 1'b1;
      tmr_val  = lo_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      st_q  <= NBS_IDLE;
      op_q  <= NBS_CMD;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      op_q  <= op_d;
      rem_q <= rem_d;
    end
  end

  assign capture = (st_q == NBS_LO) && tmr_last && (op_q == NBS_RDATA);

  nbs_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_ln   (rst_ln),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  nbs_byte_src #(.DW(DW), .AB(AB)) u_bytes (
    .clk      (clk),
    .rst_ln   (rst_ln),
    .accept   (accept),
    .acc_cmd  (req_cmd),
    .acc_addr (req_addr),
    .op       (op_q),
    .go_lo    (go_lo),
    .wr_data  (wr_data),
    .io_out   (nand_io_out)
  );

  nbs_rd_buf #(.DW(DW)) u_rdbuf (
    .clk      (clk),
    .rst_ln   (rst_ln),
    .capture  (capture),
    .din      (nand_io_in),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
  );

  assign busy       = (st_q != NBS_IDLE);
  assign req_ready  = !busy;
  assign wr_ready   = go_lo && (op_q == NBS_WDATA);
  assign nand_ce_n  = !busy;
  assign nand_cle   = busy && (op_q == NBS_CMD);
  assign nand_ale   = busy && (op_q == NBS_ADDR);
  assign nand_we_n  = !((st_q == NBS_LO) && (op_q != NBS_RDATA));
  assign nand_re_n  = !((st_q == NBS_LO) && (op_q == NBS_RDATA));
  assign nand_io_oe = busy && (op_q != NBS_RDATA);

  // checker support: length of the current strobe low phase
  logic [CW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)                      low_run_q <= '0;
    else if (!nand_we_n || !nand_re_n) low_run_q <= low_run_q + CW'(1);
    else                              low_run_q <= '0;
  end

  // R6: write strobe low phase has the programmed length
  a_r6_we_low_width: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(nand_we_n) |-> (low_run_q == ((cfg_we_lo == '0) ? CW'(1) : cfg_we_lo)));

  // R6: read strobe low phase has the programmed length
  a_r6_re_low_width: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(nand_re_n) |-> (low_run_q == ((cfg_re_lo == '0) ? CW'(1) : cfg_re_lo)));

  // R9: latch enables and bus byte hold while a write strobe is low
  a_r9_stable_under_we: assert property (@(posedge clk) disable iff (!rst_ln)
    (!nand_we_n && $past(!nand_we_n)) |->
      ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_io_out)));

  // R7: a read strobe only starts when the holding register was empty
  a_r7_no_read_when_full: assert property (@(posedge clk) disable iff (!rst_ln)
    $fell(nand_re_n) |-> $past(!rd_valid));

  // R4: an accepted write byte is strobed in the following cycle
  a_r4_take_then_strobe: assert property (@(posedge clk) disable iff (!rst_ln)
    (wr_valid && wr_ready) |=> !nand_we_n);

  // R8: busy only ends after a strobe high phase
  a_r8_busy_ends_high: assert property (@(posedge clk) disable iff (!rst_ln)
    $fell(busy) |-> $past(nand_we_n && nand_re_n));
endmodule

// File: tb/nand_bus_seq_tb_top.sv
`timescale 1ns/1ps
module nand_bus_seq_tb_top;
  localparam int DW = 8, AB = 5, CW = 4, LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [CW-1:0] cfg_we_lo = 4'd1, cfg_we_hi = 4'd1, cfg_re_lo = 4'd1, cfg_re_hi = 4'd1;
  logic req_valid = 1'b0, req_ready, busy;
  logic [1:0] req_op = 2'd0;
  logic [DW-1:0] req_cmd = '0;
  logic [AB*DW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic ce_n, cle, ale, we_n, re_n, io_oe;
  logic [DW-1:0] io_out;
  logic [DW-1:0] io_in = '0;

  nand_bus_seq #(.DW(DW), .AB(AB), .CW(CW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi), .cfg_re_lo(cfg_re_lo), .cfg_re_hi(cfg_re_hi),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
    .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_io_in(io_in)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n);
    return 8'hC3 ^ 8'(n * 37);
  endfunction

  // scoreboard queues
  logic [9:0]    exp_bus[$];
  string         exp_tag[$];
  logic [7:0]    exp_rd[$];
  logic [7:0]    wr_q[$];
  int            rd_exp_n = 0, rd_src_n = 0;
  bit            src_en = 1'b1, ready_en = 1'b1;
  int            e_we_lo = 1, e_we_hi = 1, e_re_lo = 1, e_re_hi = 1, e_tail = 1;
  int            we_pulses = 0, re_pulses = 0, viol = 0;

  task automatic set_cfg(input int wl, input int wh, input int rl, input int rh);
    cfg_we_lo = CW'(wl); cfg_we_hi = CW'(wh); cfg_re_lo = CW'(rl); cfg_re_hi = CW'(rh);
    e_we_lo = (wl == 0) ? 1 : wl; e_we_hi = (wh == 0) ? 1 : wh;
    e_re_lo = (rl == 0) ? 1 : rl; e_re_hi = (rh == 0) ? 1 : rh;
  endtask

  // write stream source
  initial begin
    forever begin
      @(negedge clk);
      wr_valid = src_en && (wr_q.size() > 0);
      wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
      #1;
      if (wr_valid && wr_ready) void'(wr_q.pop_front());
    end
  end

  // read stream consumer / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      rd_ready = ready_en;
      #1;
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) chk(1'b0, "R5", "unexpected read byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd.pop_front();
          chk(rd_data == e, "R5", "read byte", rd_data, e);
        end
      end
    end
  end

  // bus monitor, flash model and phase timing
  initial begin
    logic p_we, p_re, p_cle, p_ale, p_oe, p_ce, p_busy;
    logic [7:0] p_io;
    int cyc, we_lo_c, we_hi_c, re_lo_c, re_hi_c, last_rise;
    bit seen_we, seen_re;
    p_we = 1; p_re = 1; p_cle = 0; p_ale = 0; p_oe = 0; p_ce = 1; p_busy = 0; p_io = 0;
    cyc = 0; we_lo_c = 0; we_hi_c = 0; re_lo_c = 0; re_hi_c = 0; last_rise = 0;
    seen_we = 0; seen_re = 0;
    forever begin
      @(negedge clk);
      #2;
      cyc++;
      if (!rst_n) begin
        p_busy = 0;
      end else begin
        if (!we_n) begin
          if (p_we) begin
            if (seen_we) chk(we_hi_c >= e_we_hi, "R6", "we high gap", we_hi_c, e_we_hi);
            we_lo_c = 1;
          end else we_lo_c++;
        end else if (!p_we) begin
          we_pulses++;
          chk(we_lo_c == e_we_lo, "R6", "we low width", we_lo_c, e_we_lo);
          if (exp_bus.size() == 0) chk(1'b0, "R3", "extra write strobe", {p_cle, p_ale, p_io}, 0);
          else begin
            logic [9:0] e;
            string t;
            e = exp_bus.pop_front();
            t = exp_tag.pop_front();
            chk({p_cle, p_ale, p_io} == e, t, "latch/byte at we rise", {p_cle, p_ale, p_io}, e);
            chk(!p_ce && p_re && p_oe, t, "ce/re/oe during write", {p_ce, p_re, p_oe}, 3'b011);
          end
          seen_we = 1; we_hi_c = 1; last_rise = cyc;
        end else we_hi_c++;

        if (!re_n) begin
          if (p_re) begin
            if (seen_re) chk(re_hi_c >= e_re_hi, "R6", "re high gap", re_hi_c, e_re_hi);
            re_lo_c = 1;
            io_in = pat(rd_src_n);
            rd_src_n++;
          end else re_lo_c++;
        end else if (!p_re) begin
          re_pulses++;
          chk(re_lo_c == e_re_lo, "R6", "re low width", re_lo_c, e_re_lo);
          chk(!p_cle && !p_ale && p_we && !p_oe && !p_ce, "R5", "lines during read",
              {p_cle, p_ale, p_we, p_oe, p_ce}, 5'b00100);
          seen_re = 1; re_hi_c = 1; last_rise = cyc;
        end else re_hi_c++;

        if (p_busy && !busy) begin
          chk(cyc - last_rise == e_tail, "R8", "busy tail after last strobe", cyc - last_rise, e_tail);
          seen_we = 0; seen_re = 0;
        end
        if (!we_n && !re_n) viol++;
        if (!re_n && io_oe) viol++;
        if (busy && ce_n) viol++;
        p_busy = busy;
      end
      p_we = we_n; p_re = re_n; p_cle = cle; p_ale = ale; p_oe = io_oe; p_ce = ce_n; p_io = io_out;
    end
  end

  task automatic check_idle(input string what);
    chk(ce_n && we_n && re_n && !cle && !ale && !io_oe && !busy && req_ready, "R1", what,
        {ce_n, we_n, re_n, cle, ale, io_oe, busy, req_ready}, 8'b11100001);
  endtask

  task automatic start_op(input int op, input logic [7:0] cmd, input logic [39:0] addr,
                          input int len);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    we_pulses = 0; re_pulses = 0;
    e_tail = (op == 3) ? e_re_hi : e_we_hi;
    req_op = 2'(op); req_cmd = cmd; req_addr = addr; req_len = LW'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(busy && !req_ready, "R8", "busy after accept", {busy, req_ready}, 2'b10);
  endtask

  task automatic wait_done(input string tag);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    #3;
    chk(exp_bus.size() == 0, tag, "missing write strobes", exp_bus.size(), 0);
    chk(exp_rd.size() == 0, tag, "missing read bytes", exp_rd.size(), 0);
    check_idle("idle after operation");
  endtask

  task automatic push_bus(input logic c, input logic a, input logic [7:0] b, input string t);
    exp_bus.push_back({c, a, b});
    exp_tag.push_back(t);
  endtask

  task automatic do_cmd(input logic [7:0] c);
    push_bus(1'b1, 1'b0, c, "R2");
    start_op(0, c, '0, 0);
    wait_done("R2");
    chk(we_pulses == 1, "R2", "command pulse count", we_pulses, 1);
  endtask

  task automatic do_wdata(input int n, input int base);
    int m;
    m = (n == 0) ? 1 : n;
    for (int i = 0; i < m; i++) begin
      push_bus(1'b0, 1'b0, 8'(base + i * 17), "R4");
      wr_q.push_back(8'(base + i * 17));
    end
    start_op(2, 8'h00, '0, n);
  endtask

  task automatic do_rdata(input int n);
    int m;
    m = (n == 0) ? 1 : n;
    for (int i = 0; i < m; i++) begin
      exp_rd.push_back(pat(rd_exp_n));
      rd_exp_n++;
    end
    start_op(3, 8'h00, '0, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    check_idle("reset state");

    // R2 command with unit timing
    set_cfg(1, 1, 1, 1);
    do_cmd(8'h70);

    // R3 address, least significant byte first
    for (int i = 0; i < 5; i++) push_bus(1'b0, 1'b1, 8'h1E + 8'(i * 15), "R3");
    start_op(1, 8'h00, 40'h5A_4B_3C_2D_1E, 0);
    wait_done("R3");
    chk(we_pulses == 5, "R3", "address pulse count", we_pulses, 5);

    // R4 / R6 data in with wider phases
    set_cfg(3, 2, 1, 1);
    do_wdata(4, 8'h10);
    wait_done("R4");
    chk(we_pulses == 4, "R4", "data-in pulse count", we_pulses, 4);

    // R4 write stream empty: no strobe until data arrives
    src_en = 1'b0;
    do_wdata(3, 8'h80);
    repeat (12) @(negedge clk);
    #3;
    chk(we_pulses == 0 && busy && we_n, "R4", "no strobe while stream empty",
        {we_pulses, busy, we_n}, 3);
    src_en = 1'b1;
    wait_done("R4");
    chk(we_pulses == 3, "R4", "stalled burst pulse count", we_pulses, 3);

    // R5 / R6 data out
    set_cfg(1, 1, 2, 3);
    do_rdata(5);
    wait_done("R5");
    chk(re_pulses == 5 && we_pulses == 0, "R5", "read pulse counts", {re_pulses, we_pulses}, 5 << 32);

    // R7 consumer stall
    ready_en = 1'b0;
    do_rdata(3);
    while (!rd_valid) @(negedge clk);
    begin
      logic [7:0] held;
      #3;
      held = rd_data;
      repeat (15) @(negedge clk);
      #3;
      chk(rd_valid && rd_data == held, "R7", "held byte while stalled", rd_data, held);
      chk(re_pulses == 1, "R7", "no new read strobe while full", re_pulses, 1);
    end
    ready_en = 1'b1;
    wait_done("R7");
    chk(re_pulses == 3, "R7", "read pulses after release", re_pulses, 3);

    // R6 zero configuration acts as one; R4 zero length is one byte
    set_cfg(0, 0, 0, 0);
    do_wdata(0, 8'hA5);
    wait_done("R4");
    chk(we_pulses == 1, "R4", "zero length is one byte", we_pulses, 1);

    // R8 longer tail
    set_cfg(4, 4, 1, 1);
    do_cmd(8'hFF);
    do_rdata(0);
    wait_done("R5");
    chk(re_pulses == 1, "R5", "zero length read is one byte", re_pulses, 1);

    chk(viol == 0, "R9", "strobe overlap, driven bus during read, or ce high while busy", viol, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule